// File: doc/BRIEF.md
# Read Return Path from Memory Controller to AHB

This block sits behind an AHB slave front end and carries read data from a memory controller back onto the AHB read data bus. The memory controller delivers read beats on a valid/ready stream. Each beat has a data word and a flag that marks the final beat of a burst. The block holds those beats in a small buffer and releases them one per AHB read data phase. While no beat is ready, the data phase is stretched with HREADY low.

For each burst, the front end loads the number of beats it expects. It then raises a one-cycle beat request for each AHB read data phase. The block counts the beats it hands out and compares the end-of-burst flag against that count. If the flag comes too early, or the count runs out without the flag, the affected data phase ends with the two-cycle AHB ERROR response instead of data. The response is encoded as 2'b00 for OKAY and 2'b01 for ERROR.

Top module: `rd_return_bridge`

## Requirements
- R1: While reset is held and right after it, hready is 1, hresp is 2'b00, hrdata is all zero and rx_ready is 1.
- R2: A beat is taken from the stream only on a rising edge where rx_valid and rx_ready are both 1. rx_ready is 0 exactly when DEPTH beats are buffered. A beat held on the stream while rx_ready is 0 is taken later, and none is lost or duplicated.
- R3: A beat_req sampled while hready is 1 makes hready 0 in the following cycle, so every read data phase has at least one wait state.
- R4: A waiting data phase takes the oldest buffered beat on the first edge where one is present. In the next cycle hready is 1, hresp is 2'b00 and hrdata carries that beat. Beats come out in arrival order.
- R5: cmd_load loads cmd_beats as the expected beat count. A burst of that many beats, with rx_last set only on the final one, completes every data phase with OKAY. A new beat_req may be raised in the very cycle a phase completes.
- R6: A beat with rx_last set before the expected count is reached gives an ERROR response. The first cycle shows hresp 2'b01 with hready 0, the second shows hresp 2'b01 with hready 1, and hrdata is zero in both.
- R7: The beat that reaches the expected count without rx_last set gives the same two-cycle ERROR response as in R6, in place of its data.
- R8: After an ERROR the expected count is zero. Any beat handed out before the next cmd_load gives the two-cycle ERROR response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| cmd_load | input | 1 | Loads the expected beat count for a new read burst |
| cmd_beats | input | CNT_W | Number of beats expected in the burst |
| beat_req | input | 1 | One-cycle pulse: an AHB read data phase starts next cycle |
| rx_data | input | DATA_W | Read data word from the memory controller |
| rx_valid | input | 1 | rx_data and rx_last are valid |
| rx_last | input | 1 | Marks the final beat of a read burst |
| rx_ready | output | 1 | The beat buffer can take a beat |
| hrdata | output | DATA_W | AHB read data |
| hready | output | 1 | AHB transfer done; low inserts wait states |
| hresp | output | 2 | AHB response: 2'b00 OKAY, 2'b01 ERROR |

## Verification
If the buffer pointers or occupancy go wrong, the ports show it within one data phase. Either a word comes out of order or twice on hrdata, or rx_ready stays low with free space and the data phase never completes. A beat count that is off by one turns a good last beat into an ERROR, or lets a short burst finish with OKAY. The bench sees that at the data phase that carries the bad beat. A broken response sequencer shows up as a single-cycle ERROR, or as non-zero hrdata during ERROR, in the cycle right after the bad beat is taken.

// File: rtl/rrb_pkg.sv
package rrb_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_WAIT,
    ST_ERR
  } phase_t;

  localparam logic [1:0] RESP_OKAY  = 2'b00;
  localparam logic [1:0] RESP_ERROR = 2'b01;
endpackage

// File: rtl/rrb_fifo.sv
module rrb_fifo #(
  parameter int W     = 33,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic [W-1:0] wdata,
  input  logic         pop,
  output logic [W-1:0] rdata,
  output logic         empty,
  output logic         full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] count;

  // storage without reset so it can map to RAM
  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      if (pop)  rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assign rdata = mem[rd_ptr];
  assign empty = (count == '0);
  assign full  = (count == CW'(DEPTH));
endmodule

// File: rtl/rrb_beat_ctr.sv
module rrb_beat_ctr #(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             take,
  input  logic             take_last,
  output logic             mismatch
);
  logic [CNT_W-1:0] remaining;
  logic             final_due;

  assign final_due = (remaining == CNT_W'(1));
  // a zero count means no burst is open: every beat is out of place
  assign mismatch  = (remaining == '0) || (take_last != final_due);

  always_ff @(posedge clk) begin
    if (rst) begin
      remaining <= '0;
    end else if (load) begin
      remaining <= load_val;
    end else if (take) begin
      remaining <= mismatch ? '0 : remaining - 1'b1;
    end
  end
endmodule

// File: rtl/rrb_ahb_fsm.sv
module rrb_ahb_fsm #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              beat_req,
  input  logic              have_beat,
  input  logic [DATA_W-1:0] beat_data,
  input  logic              bad_beat,
  output logic              pop,
  output logic [DATA_W-1:0] hrdata,
  output logic              hready,
  output logic [1:0]        hresp
);
  import rrb_pkg::*;

  phase_t state;

  assign pop = (state == ST_WAIT) && have_beat;

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_IDLE;
      hready <= 1'b1;
      hresp  <= RESP_OKAY;
      hrdata <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          hready <= 1'b1;
          hresp  <= RESP_OKAY;
          if (beat_req) begin
            state  <= ST_WAIT;
            hready <= 1'b0;
          end
        end
        ST_WAIT: begin
          if (pop) begin
            if (bad_beat) begin
              state  <= ST_ERR;
              hresp  <= RESP_ERROR;
              hrdata <= '0;
            end else begin
              state  <= ST_IDLE;
              hready <= 1'b1;
              hresp  <= RESP_OKAY;
              hrdata <= beat_data;
            end
          end
        end
        ST_ERR: begin
          state  <= ST_IDLE;
          hready <= 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/rd_return_bridge.sv
module rd_return_bridge #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 4,
  parameter int CNT_W  = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_load,
  input  logic [CNT_W-1:0]  cmd_beats,
  input  logic              beat_req,
  input  logic [DATA_W-1:0] rx_data,
  input  logic              rx_valid,
  input  logic              rx_last,
  output logic              rx_ready,
  output logic [DATA_W-1:0] hrdata,
  output logic              hready,
  output logic [1:0]        hresp
);
  localparam int EW = DATA_W + 1;

  logic          buf_full, buf_empty, push_en, pop_en, bad_beat;
  logic [EW-1:0] head;

  assign rx_ready = !buf_full;
  assign push_en  = rx_valid && rx_ready;

  rrb_fifo #(.W(EW), .DEPTH(DEPTH)) u_fifo (
    .clk   (clk),
    .rst   (rst),
    .push  (push_en),
    .wdata ({rx_last, rx_data}),
    .pop   (pop_en),
    .rdata (head),
    .empty (buf_empty),
    .full  (buf_full)
  );

  rrb_beat_ctr #(.CNT_W(CNT_W)) u_ctr (
    .clk       (clk),
    .rst       (rst),
    .load      (cmd_load),
    .load_val  (cmd_beats),
    .take      (pop_en),
    .take_last (head[DATA_W]),
    .mismatch  (bad_beat)
  );

  rrb_ahb_fsm #(.DATA_W(DATA_W)) u_fsm (
    .clk       (clk),
    .rst       (rst),
    .beat_req  (beat_req),
    .have_beat (!buf_empty),
    .beat_data (head[DATA_W-1:0]),
    .bad_beat  (bad_beat),
    .pop       (pop_en),
    .hrdata    (hrdata),
    .hready    (hready),
    .hresp     (hresp)
  );
endmodule

// File: rtl/rrb_checker.sv
module rrb_checker #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              rx_valid,
  input logic              rx_ready,
  input logic              beat_req,
  input logic              hready,
  input logic [1:0]        hresp,
  input logic [DATA_W-1:0] hrdata,
  input logic              pop_en
);
  localparam int OW = $clog2(DEPTH + 1) + 1;

  logic [OW-1:0] occ;
  logic          acc;

  assign acc = rx_valid && rx_ready;

  always_ff @(posedge clk) begin
    if (rst) occ <= '0;
    else     occ <= occ + OW'(acc) - OW'(pop_en);
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    occ <= OW'(DEPTH)); // R2
  AST_READY_WHEN_SPACE: assert property (@(posedge clk) disable iff (rst)
    (occ < OW'(DEPTH)) |-> rx_ready); // R2
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (rst)
    pop_en |-> (occ != '0)); // R4
  AST_WAIT_AFTER_REQ: assert property (@(posedge clk) disable iff (rst)
    (beat_req && hready) |=> !hready); // R3
  AST_ERR_SECOND: assert property (@(posedge clk) disable iff (rst)
    (hresp == 2'b01 && !hready) |=> (hresp == 2'b01 && hready)); // R6
  AST_ERR_FIRST: assert property (@(posedge clk) disable iff (rst)
    (hresp == 2'b01 && hready) |-> $past(hresp == 2'b01 && !hready)); // R7
  AST_ERR_ZERO_DATA: assert property (@(posedge clk) disable iff (rst)
    (hresp == 2'b01) |-> (hrdata == '0)); // R6
endmodule

bind rd_return_bridge rrb_checker #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .rx_valid (rx_valid),
  .rx_ready (rx_ready),
  .beat_req (beat_req),
  .hready   (hready),
  .hresp    (hresp),
  .hrdata   (hrdata),
  .pop_en   (pop_en)
);

// File: tb/test_rd_return_bridge.sv
module test_rd_return_bridge;
  localparam int CLK_PERIOD = 10;
  localparam int DATA_W = 32;
  localparam int DEPTH  = 4;
  localparam int CNT_W  = 5;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              cmd_load = 1'b0;
  logic [CNT_W-1:0]  cmd_beats = '0;
  logic              beat_req = 1'b0;
  logic [DATA_W-1:0] rx_data = '0;
  logic              rx_valid = 1'b0;
  logic              rx_last = 1'b0;
  logic              rx_ready;
  logic [DATA_W-1:0] hrdata;
  logic              hready;
  logic [1:0]        hresp;

  int  n_chk = 0;
  int  n_fail = 0;
  bit  finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rd_return_bridge #(.DATA_W(DATA_W), .DEPTH(DEPTH), .CNT_W(CNT_W)) i_rd_return_bridge (
    .clk(clk), .rst(rst), .cmd_load(cmd_load), .cmd_beats(cmd_beats),
    .beat_req(beat_req), .rx_data(rx_data), .rx_valid(rx_valid),
    .rx_last(rx_last), .rx_ready(rx_ready), .hrdata(hrdata),
    .hready(hready), .hresp(hresp)
  );

  function automatic logic [DATA_W-1:0] beat_val(int b, int i);
    return DATA_W'(b * 32'h0100_0193 + (i + 1) * 32'h9E37_79B9);
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // stream side: beat i carries rx_last when i == last_at
  task automatic send_burst(int b, int n, int last_at, bit gaps);
    for (int i = 0; i < n; i++) begin
      if (gaps) repeat ($urandom_range(0, 2)) @(negedge clk);
      rx_valid = 1'b1;
      rx_data  = beat_val(b, i);
      rx_last  = (i == last_at);
      begin
        bit took;
        do begin
          took = rx_ready;
          @(negedge clk);
        end while (!took);
      end
      rx_valid = 1'b0;
      rx_last  = 1'b0;
    end
  endtask

  // AHB side: beat err_at expects ERROR and ends the burst
  task automatic read_burst(int b, int n, int err_at, bit load, string tag);
    for (int i = 0; i < n; i++) begin
      beat_req  = 1'b1;
      cmd_load  = load && (i == 0);
      cmd_beats = CNT_W'(n);
      @(negedge clk);
      beat_req = 1'b0;
      cmd_load = 1'b0;
      chk(hready == 1'b0, "R3", 64'(hready), 64'd0);
      while (!hready && hresp != 2'b01) @(negedge clk);
      if (i == err_at) begin
        chk(hresp == 2'b01 && !hready, tag, 64'({hresp, hready}), 64'b010);
        @(negedge clk);
        chk(hresp == 2'b01 && hready && hrdata == '0, tag,
            64'({hresp, hready, hrdata}), 64'({2'b01, 1'b1, 32'd0}));
        return;
      end
      chk(hresp == 2'b00 && hrdata == beat_val(b, i), tag,
          64'({hresp, hrdata}), 64'({2'b00, beat_val(b, i)}));
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    // R1: values during reset and just after release
    chk(hready && hresp == 2'b00 && hrdata == '0 && rx_ready, "R1",
        64'({hready, hresp, rx_ready}), 64'b1001);
    rst = 1'b0;
    @(negedge clk);
    chk(hready && hresp == 2'b00 && hrdata == '0 && rx_ready, "R1",
        64'({hready, hresp, rx_ready}), 64'b1001);

    // R2: fill the buffer, hold a fifth beat, then drain all in order
    fork
      send_burst(100, DEPTH + 1, DEPTH, 1'b0);
      begin
        repeat (DEPTH + 4) @(negedge clk);
        chk(rx_ready == 1'b0, "R2", 64'(rx_ready), 64'd0);
        read_burst(100, DEPTH + 1, -1, 1'b1, "R2");
      end
    join

    // R5 / R4: random bursts with random stream gaps
    for (int b = 0; b < 20; b++) begin
      int n;
      n = $urandom_range(1, 8);
      fork
        send_burst(b, n, n - 1, 1'b1);
        read_burst(b, n, -1, 1'b1, "R5");
      join
    end

    // R6: rx_last on first beat of a three-beat burst
    fork
      send_burst(200, 1, 0, 1'b0);
      read_burst(200, 3, 0, 1'b1, "R6");
    join

    // R8: no new load after the error, stray beat must fail
    fork
      send_burst(201, 1, 0, 1'b0);
      read_burst(201, 1, 0, 1'b0, "R8");
    join

    // R7: two-beat burst whose final beat lacks rx_last
    fork
      send_burst(202, 2, -1, 1'b0);
      read_burst(202, 2, 1, 1'b1, "R7");
    join

    // R4: normal operation resumes after errors
    fork
      send_burst(203, 3, 2, 1'b1);
      read_burst(203, 3, -1, 1'b1, "R4");
    join

    repeat (2) @(negedge clk);
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule